// File: doc/BRIEF.md
# Carry-Save Tree Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. Every partial product is formed at once: row i is the multiplicand gated by bit i of the multiplier and moved up i places. A balanced tree of 3-to-2 carry-save stages then reduces the rows. Each stage is a rank of independent full adders, and no carry travels sideways inside a stage. Once two vectors remain, a single parallel-prefix adder resolves them into the product.

The reduction runs at full 2N-bit width, so no carry can be lost before the last addition. A parameter selects whether the product leaves through a reset register or straight from the adder. The default is eight-bit operands with a registered output. That gives eight rows, reduced in four stage levels (8, 6, 4, 3, 2).

Top module: `cst_mult`

## Requirements
- R1: `product` equals the unsigned value `op_a` times `op_b`, exact in all 2N bits, for every operand pair.
- R2: Row i of the partial products is zero whenever `op_b[i]` is 0. A multiplier with only bit i set yields `op_a` shifted left by i.
- R3: Every carry-save stage keeps its value. Its sum vector plus its carry vector, where the carry vector is already moved up one place, equals the sum of its three inputs modulo 2^(2N).
- R4: The two vectors left at the end of the tree add, modulo 2^(2N), to the product of the operands.
- R5: With `REG_OUT`=1, `product` shows the result for the operands present at the previous rising edge of `clk`. While `rst_n` is low, `product` is 0.
- R6: With `REG_OUT`=0, `product` follows the operands with no clock involved.
- R7: Corner operands give the expected extremes: zero on either side gives 0, and the largest times the largest gives (2^N-1)^2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| op_a | input | N | Multiplicand, unsigned |
| op_b | input | N | Multiplier, unsigned |
| product | output | 2N | Unsigned product |

## Verification
A four-bit combinational instance is driven through all 256 operand pairs. This separates any fault in how the tree groups rows from a fault in a single column or carry weight. On the eight-bit registered instance, multipliers with a single bit set check each partial-product row and its shift on its own. All-ones operands fill every column, push carries through every stage and through the full prefix adder, and zero operands check that nothing leaks in. Random pairs cover mixed patterns. A latency check shows that the registered output holds its value until the clock edge.

// File: rtl/cst_pkg.sv
package cst_pkg;

  // rows left after one level of 3-to-2 reduction
  function automatic int rows_after(input int c);
    return 2 * (c / 3) + (c % 3);
  endfunction

  // rows present at the input of level lv
  function automatic int rows_at(input int n, input int lv);
    int c;
    c = n;
    for (int k = 0; k < lv; k++) c = rows_after(c);
    return c;
  endfunction

  // number of levels until two rows remain
  function automatic int tree_levels(input int n);
    int c;
    int l;
    c = n;
    l = 0;
    while (c > 2) begin
      c = rows_after(c);
      l++;
    end
    return l;
  endfunction

  // full-adder sum and majority, kept as functions so the arithmetic is visible
  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic fa_maj(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  // prefix operator: {generate, propagate} of a high span joined with a low span
  function automatic logic [1:0] pg_join(input logic [1:0] hi, input logic [1:0] lo);
    return {hi[1] | (hi[0] & lo[1]), hi[0] & lo[0]};
  endfunction

endpackage

// File: rtl/cst_csa.sv
module cst_csa #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  import cst_pkg::*;

  logic [W-1:0] maj;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i]   = fa_sum(x[i], y[i], z[i]);
    assign maj[i] = fa_maj(x[i], y[i], z[i]);
  end

  // carry weighs one place more; top majority bit is beyond 2N and is zero in a valid tree
  assign c = {maj[W-2:0], 1'b0};

  // R3: the stage keeps the value of its three inputs
  always_comb begin
    p_csa_balance_r3: assert (W'(s + c) == W'(x + y + z));
  end

endmodule

// File: rtl/cst_tree.sv
module cst_tree #(
  parameter int N = 8,
  parameter int W = 2 * N
) (
  input  logic [N-1:0][W-1:0] rows,
  output logic [W-1:0]        vec_x,
  output logic [W-1:0]        vec_y
);
  import cst_pkg::*;

  localparam int LV = tree_levels(N);

  logic [N-1:0][W-1:0] lvl [LV+1];

  assign lvl[0] = rows;

  for (genvar l = 0; l < LV; l++) begin : g_lv
    localparam int CIN  = rows_at(N, l);
    localparam int NG   = CIN / 3;
    localparam int REM  = CIN % 3;
    localparam int COUT = 2 * NG + REM;

    for (genvar g = 0; g < NG; g++) begin : g_csa
      cst_csa #(.W(W)) u_csa (
        .x(lvl[l][3*g]),
        .y(lvl[l][3*g+1]),
        .z(lvl[l][3*g+2]),
        .s(lvl[l+1][2*g]),
        .c(lvl[l+1][2*g+1])
      );
    end

    for (genvar r = 0; r < REM; r++) begin : g_pass
      assign lvl[l+1][2*NG+r] = lvl[l][3*NG+r];
    end

    for (genvar r = COUT; r < N; r++) begin : g_idle
      assign lvl[l+1][r] = '0;
    end
  end

  assign vec_x = lvl[LV][0];
  assign vec_y = lvl[LV][1];

endmodule

// File: rtl/cst_prefix_add.sv
module cst_prefix_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  import cst_pkg::*;

  localparam int STG = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] gen [STG+1];
  logic [W-1:0] prp [STG+1];
  logic [W-1:0] cin_v;

  assign gen[0] = a & b;
  assign prp[0] = a ^ b;

  for (genvar k = 0; k < STG; k++) begin : g_stage
    localparam int D = 1 << k;
    for (genvar i = 0; i < W; i++) begin : g_col
      if (i >= D) begin : g_join
        assign {gen[k+1][i], prp[k+1][i]} =
          pg_join({gen[k][i], prp[k][i]}, {gen[k][i-D], prp[k][i-D]});
      end else begin : g_keep
        assign gen[k+1][i] = gen[k][i];
        assign prp[k+1][i] = prp[k][i];
      end
    end
  end

  assign cin_v = {gen[STG][W-2:0], 1'b0};
  assign s     = prp[0] ^ cin_v;

endmodule

// File: rtl/cst_mult.sv
module cst_mult #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  output logic [2*N-1:0] product
);
  localparam int W = 2 * N;

  logic [N-1:0][W-1:0] pp_rows;
  logic [W-1:0]        fin_x;
  logic [W-1:0]        fin_y;
  logic [W-1:0]        sum_comb;
  logic [W-1:0]        ref_prod;
  logic                past_ok;

  for (genvar i = 0; i < N; i++) begin : g_pp
    assign pp_rows[i] = (W'(op_a) << i) & {W{op_b[i]}};
  end

  cst_tree #(.N(N), .W(W)) u_tree (
    .rows (pp_rows),
    .vec_x(fin_x),
    .vec_y(fin_y)
  );

  cst_prefix_add #(.W(W)) u_add (
    .a(fin_x),
    .b(fin_y),
    .s(sum_comb)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) product <= '0;
      else        product <= sum_comb;
    end
  end else begin : g_comb
    assign product = sum_comb;
  end

  // checking aids
  assign ref_prod = W'(op_a) * W'(op_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_tree_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    W'(fin_x + fin_y) == ref_prod);

  p_adder_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sum_comb == ref_prod);

  for (genvar i = 0; i < N; i++) begin : g_pp_chk
    p_row_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !op_b[i] |-> (pp_rows[i] == '0));
  end

  if (REG_OUT) begin : g_reg_chk
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (product == $past(ref_prod)));
  end else begin : g_comb_chk
    p_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      product == ref_prod);
  end

endmodule

// File: tb/cst_mult_tb.sv
module cst_mult_tb;

  localparam int N  = 8;
  localparam int N4 = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    a8 = '0, b8 = '0;
  logic [2*N-1:0]  p8;
  logic [N4-1:0]   a4 = '0, b4 = '0;
  logic [2*N4-1:0] p4;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  cst_mult #(.N(N), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(a8), .op_b(b8), .product(p8)
  );

  cst_mult #(.N(N4), .REG_OUT(1'b0)) u_dut4 (
    .clk(clk), .rst_n(rst_n), .op_a(a4), .op_b(b4), .product(p4)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0h expected=%0h", req, got, exp);
    end
  endtask

  // shift-and-add reference, written independently of the tree
  function automatic logic [31:0] sa_mul(input logic [15:0] x, input logic [15:0] y, input int n);
    logic [31:0] acc;
    acc = 0;
    for (int i = 0; i < n; i++) if (y[i]) acc = acc + (32'(x) << i);
    return acc;
  endfunction

  // apply on 8-bit registered DUT and sample at the next falling edge
  task automatic apply8(input logic [7:0] x, input logic [7:0] y, input string req);
    @(negedge clk);
    a8 = x; b8 = y;
    @(negedge clk);
    chk(req, 32'(p8), sa_mul(16'(x), 16'(y), N));
  endtask

  task automatic t_reset;
    a8 = 8'hA5; b8 = 8'h3C;
    #2;
    chk("R5 reset clears product", 32'(p8), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_corners;
    apply8(8'h00, 8'hFF, "R7 zero multiplicand");
    apply8(8'hFF, 8'h00, "R7 zero multiplier");
    apply8(8'hFF, 8'hFF, "R7 R3 R4 max times max");
    apply8(8'h01, 8'h01, "R7 one times one");
  endtask

  task automatic t_onehot;
    for (int i = 0; i < N; i++) apply8(8'hB7, 8'(1 << i), "R2 single multiplier bit");
  endtask

  task automatic t_random;
    for (int k = 0; k < 200; k++)
      apply8(8'($urandom()), 8'($urandom()), "R1 random operands");
  endtask

  task automatic t_latency;
    @(negedge clk);
    a8 = 8'd3; b8 = 8'd5;
    @(negedge clk);
    a8 = 8'd7; b8 = 8'd9;
    #1;
    chk("R5 output holds before edge", 32'(p8), 32'd15);
    @(negedge clk);
    chk("R5 output updates after edge", 32'(p8), 32'd63);
  endtask

  task automatic t_exhaustive4;
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        a4 = 4'(x); b4 = 4'(y);
        #1;
        chk("R6 R1 four-bit exhaustive", 32'(p4), sa_mul(16'(x), 16'(y), N4));
      end
    end
  endtask

  initial begin : watchdog
    #1_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: got=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_corners();
    t_onehot();
    t_latency();
    t_random();
    t_exhaustive4();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule